// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a bus slave on a two-wire serial bus (SCL clock, SDA data) that behaves like a 512-byte electrically erasable memory. The storage is an internal register array. SDA is split into an input, an output enable and an output value, so a pad or a bench can build the open bus line. A bus master reaches the block by sending a device-address byte. Two strap inputs fill in part of that byte, which lets several copies share one bus.

A write loads an address counter and then collects up to sixteen data bytes in a page buffer. The block commits the buffer to the array when a stop condition arrives, then enters a self-timed busy window of `WRITE_CYCLES` system clocks. During that window it refuses its own address, so the master can poll for the end of the write. A write-protect input guards the upper 256 bytes.

Reads return bytes MSB first from the counter position. The counter advances after each byte and runs across the whole array. A read can start at the current counter position, or at a loaded address through a dummy write followed by a repeated start. Both bus lines are sampled by the system clock through two-stage synchronizers, so SCL must be slow compared with the system clock (400 kHz against a clock of tens of MHz).

Top module: `twowire_eeprom`

## Requirements
- R1: After reset SDA is released (sdaOe low), the address counter is 0 and every byte of the array reads 0xFF.
- R2: The device byte is bits 7..4 = 1010, bit 3 = strapA2, bit 2 = strapA1, bit 1 = block select (array address bit 8), bit 0 = direction (1 = read). The slave pulls SDA low in the ninth clock only when bits 7..2 match. Otherwise it ignores the bus until the next start.
- R3: A write of device byte (bit 0 = 0), word address and data byte, closed by a stop, stores the data at address {block select, word address}.
- R4: With wpIn high at the stop, addresses 0x100–0x1FF keep their contents, while 0x000–0x0FF still take writes. With wpIn low, all addresses take writes. Data bytes sent to protected addresses are still acknowledged.
- R5: During a write the low four address bits wrap within the 16-byte page. A seventeenth and later byte overwrites the byte at the same page position.
- R6: A stop that ends a write with at least one data byte starts a busy window of WRITE_CYCLES clocks. During the window the device byte gets no acknowledge, and after it the byte is acknowledged again.
- R7: A random read (write device byte, word address, repeated start, read device byte) returns the byte at that address, MSB first.
- R8: A current-address read returns the byte at the counter position left by the previous access, with bit 8 taken from the block-select bit.
- R9: In a read the counter advances after each byte across the whole array, wrapping from 0x1FF to 0x000. Data continues while the master acknowledges, and SDA is released after a master NACK.
- R10: The slave changes SDA only while SCL is low. It drives SDA only in its acknowledge slots and in read data bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Bus clock from the master |
| sdaIn | input | 1 | Sensed level of the bus data line |
| sdaOe | output | 1 | High while the slave drives the data line |
| sdaOut | output | 1 | Value driven on the data line when enabled |
| strapA2 | input | 1 | Device-address strap compared with device-byte bit 3 |
| strapA1 | input | 1 | Device-address strap compared with device-byte bit 2 |
| wpIn | input | 1 | Write protect for the upper half of the array |

## Verification
The bench keeps the default 512-byte array and 16-byte page, so it can reach the top-of-array wrap and the page wrap directly. It shortens WRITE_CYCLES to 1000 clocks. At that length a device byte sent right after a stop lands inside the busy window, and a short wait afterwards shows the window closing. The straps are tied to A2 = 1 and A1 = 0, so device bytes with either strap bit flipped can show the mismatch case.

// File: rtl/twowire_eeprom_pkg.sv
package twowire_eeprom_pkg;

  // Fixed device-type code expected in the upper nibble of the device byte
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_RX_DEV,
    PH_ACK_DEV,
    PH_RX_WORD,
    PH_ACK_WORD,
    PH_RX_DATA,
    PH_ACK_DATA,
    PH_TX_DATA,
    PH_TX_ACK
  } busPhase_e;

  // Single-cycle strobes from control to datapath
  typedef struct packed {
    logic shiftIn;    // shift one sampled SDA bit into the receive byte
    logic loadBlock;  // take block select from the device byte
    logic loadWord;   // load the low address byte
    logic storeByte;  // place received byte into the page buffer
    logic loadTx;     // fetch array byte into the transmit shifter
    logic shiftTx;    // move to the next transmit bit
    logic incRead;    // advance the counter across the whole array
    logic clearBuf;   // drop any buffered page data
    logic commit;     // write the page buffer into the array
  } dpStrobe_t;

endpackage

// File: rtl/twowire_eeprom_ctrl.sv
module twowire_eeprom_ctrl
  import twowire_eeprom_pkg::*;
#(
  parameter int WRITE_CYCLES = 300000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       strapA2,
  input  logic       strapA1,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  input  logic       anyPending,
  output dpStrobe_t  strobe,
  output logic       sdaBit,
  output logic       busyNow,
  output logic       sdaOe,
  output logic       sdaOut
);

  localparam int BUSY_W = $clog2(WRITE_CYCLES + 1);

  logic [1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;
  logic sclNow, sdaNow;
  logic startSeen, stopSeen, sclRise, sclFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclNow    = sclSync[1];
  assign sdaNow    = sdaSync[1];
  assign sdaBit    = sdaNow;
  assign startSeen = sclNow && sclPrev && sdaPrev && !sdaNow;
  assign stopSeen  = sclNow && sclPrev && !sdaPrev && sdaNow;
  assign sclRise   = sclNow && !sclPrev;
  assign sclFall   = !sclNow && sclPrev;

  busPhase_e phase;
  logic [3:0] bitCnt;
  logic rwReg, masterAck;
  logic [BUSY_W-1:0] busyCnt;
  logic byteIn, devMatch;

  assign byteIn   = (bitCnt == 4'd8);
  assign devMatch = (rxByte[7:4] == DEV_TYPE) && (rxByte[3] == strapA2) &&
                    (rxByte[2] == strapA1);
  assign busyNow  = (busyCnt != '0);

  always_comb begin
    strobe = '0;
    if (startSeen) begin
      strobe.clearBuf = 1'b1;
    end else if (stopSeen) begin
      strobe.commit = anyPending && !busyNow;
    end else begin
      unique case (phase)
        PH_RX_DEV, PH_RX_WORD, PH_RX_DATA: begin
          strobe.shiftIn = sclRise && !byteIn;
          if (sclFall && byteIn) begin
            if (phase == PH_RX_DEV) begin
              strobe.loadBlock = devMatch && !busyNow;
              strobe.clearBuf  = devMatch && !busyNow && !rxByte[0];
            end else if (phase == PH_RX_WORD) begin
              strobe.loadWord = 1'b1;
            end else begin
              strobe.storeByte = 1'b1;
            end
          end
        end
        PH_ACK_DEV: strobe.loadTx = sclFall && rwReg;
        PH_TX_DATA: begin
          strobe.shiftTx = sclFall && (bitCnt != 4'd7);
          strobe.incRead = sclFall && (bitCnt == 4'd7);
        end
        PH_TX_ACK: strobe.loadTx = sclFall && masterAck;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      bitCnt    <= '0;
      rwReg     <= 1'b0;
      masterAck <= 1'b0;
    end else if (startSeen) begin
      phase  <= PH_RX_DEV;
      bitCnt <= '0;
    end else if (stopSeen) begin
      phase <= PH_IDLE;
    end else begin
      unique case (phase)
        PH_RX_DEV, PH_RX_WORD, PH_RX_DATA: begin
          if (sclRise && !byteIn) bitCnt <= bitCnt + 4'd1;
          if (sclFall && byteIn) begin
            bitCnt <= '0;
            if (phase == PH_RX_DEV) begin
              if (devMatch && !busyNow) begin
                phase <= PH_ACK_DEV;
                rwReg <= rxByte[0];
              end else begin
                phase <= PH_IDLE;
              end
            end else if (phase == PH_RX_WORD) begin
              phase <= PH_ACK_WORD;
            end else begin
              phase <= PH_ACK_DATA;
            end
          end
        end
        PH_ACK_DEV: if (sclFall) begin
          phase  <= rwReg ? PH_TX_DATA : PH_RX_WORD;
          bitCnt <= '0;
        end
        PH_ACK_WORD, PH_ACK_DATA: if (sclFall) phase <= PH_RX_DATA;
        PH_TX_DATA: if (sclFall) begin
          if (bitCnt == 4'd7) phase <= PH_TX_ACK;
          else bitCnt <= bitCnt + 4'd1;
        end
        PH_TX_ACK: begin
          if (sclRise) masterAck <= !sdaNow;
          if (sclFall) begin
            bitCnt <= '0;
            phase  <= masterAck ? PH_TX_DATA : PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= '0;
    else if (strobe.commit) busyCnt <= BUSY_W'(WRITE_CYCLES);
    else if (busyNow) busyCnt <= busyCnt - 1'b1;
  end

  assign sdaOe  = (phase == PH_ACK_DEV) || (phase == PH_ACK_WORD) ||
                  (phase == PH_ACK_DATA) || (phase == PH_TX_DATA);
  assign sdaOut = (phase == PH_TX_DATA) ? txBit : 1'b0;

endmodule

// File: rtl/twowire_eeprom_dp.sv
module twowire_eeprom_dp
  import twowire_eeprom_pkg::*;
#(
  parameter int MEM_BYTES  = 512,
  parameter int PAGE_BYTES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  input  logic       sdaBit,
  input  logic       wpIn,
  output logic [7:0] rxByte,
  output logic       txBit,
  output logic       anyPending
);

  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  logic [7:0] mem [MEM_BYTES];
  logic [7:0] pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageValid;
  logic [ADDR_W-1:0] addrCnt;
  logic [7:0] txShift;
  logic guardHit;

  // Upper half of the array is guarded when the protect input is high
  assign guardHit = wpIn && addrCnt[ADDR_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      txShift <= '0;
      addrCnt <= '0;
    end else begin
      if (strobe.shiftIn) rxByte <= {rxByte[6:0], sdaBit};
      if (strobe.loadBlock) addrCnt[ADDR_W-1] <= rxByte[1];
      if (strobe.loadWord) addrCnt[ADDR_W-2:0] <= rxByte[ADDR_W-2:0];
      if (strobe.storeByte) addrCnt[PAGE_W-1:0] <= addrCnt[PAGE_W-1:0] + 1'b1;
      if (strobe.incRead) addrCnt <= addrCnt + 1'b1;
      if (strobe.loadTx) txShift <= mem[addrCnt];
      else if (strobe.shiftTx) txShift <= {txShift[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageValid <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= '0;
    end else if (strobe.clearBuf || strobe.commit) begin
      pageValid <= '0;
    end else if (strobe.storeByte) begin
      pageBuf[addrCnt[PAGE_W-1:0]]   <= rxByte;
      pageValid[addrCnt[PAGE_W-1:0]] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (strobe.commit && !guardHit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pageValid[i]) mem[{addrCnt[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pageBuf[i];
    end
  end

  assign txBit      = txShift[7];
  assign anyPending = |pageValid;

endmodule

// File: rtl/twowire_eeprom.sv
module twowire_eeprom
  import twowire_eeprom_pkg::*;
#(
  parameter int MEM_BYTES    = 512,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 300000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe,
  output logic sdaOut,
  input  logic strapA2,
  input  logic strapA1,
  input  logic wpIn
);

  dpStrobe_t  strobe;
  logic [7:0] rxByte;
  logic       txBit, anyPending, sdaBit, busyNow;

  twowire_eeprom_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strapA2(strapA2), .strapA1(strapA1), .rxByte(rxByte), .txBit(txBit),
    .anyPending(anyPending), .strobe(strobe), .sdaBit(sdaBit),
    .busyNow(busyNow), .sdaOe(sdaOe), .sdaOut(sdaOut)
  );

  twowire_eeprom_dp #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaBit(sdaBit), .wpIn(wpIn),
    .rxByte(rxByte), .txBit(txBit), .anyPending(anyPending)
  );

endmodule

// File: rtl/twowire_eeprom_chk.sv
module twowire_eeprom_chk
  import twowire_eeprom_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      sclIn,
  input logic      sdaOe,
  input logic      busyNow,
  input dpStrobe_t strobe
);

  // A commit opens the busy window on the next cycle
  assert_commit_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> busyNow);

  // No device byte is accepted and no data stored while busy
  assert_busy_refuses_R6: assert property (@(posedge clk) disable iff (!rstN)
    busyNow |-> !strobe.loadBlock && !strobe.storeByte);

  // Drive starts and ends only while the bus clock is low
  assert_drive_starts_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn);

  assert_drive_ends_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOe) |-> !sclIn);

  // Data-moving strobes never coincide
  assert_one_action_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.commit, strobe.storeByte, strobe.loadWord,
              strobe.loadBlock, strobe.loadTx, strobe.incRead}));

endmodule

bind twowire_eeprom twowire_eeprom_chk uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .busyNow(busyNow), .strobe(strobe)
);

// File: tb/twowire_eeprom_test.sv
module twowire_eeprom_test;

  localparam int WC = 1000;
  localparam int Q  = 10;

  // Fields: [25:17] address, [16:9] data, [8] protect, [7:0] expected read
  localparam logic [25:0] VECS [6] = '{
    {9'h000, 8'h5A, 1'b0, 8'h5A},
    {9'h0FF, 8'hC3, 1'b1, 8'hC3},
    {9'h100, 8'h77, 1'b1, 8'hFF},
    {9'h1FF, 8'h12, 1'b0, 8'h12},
    {9'h155, 8'h99, 1'b1, 8'hFF},
    {9'h0AA, 8'h01, 1'b0, 8'h01}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic wp = 1'b0;
  logic sdaOe, sdaOut;
  logic sdaLine;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign sdaLine = sdaOe ? sdaOut : mSda;

  twowire_eeprom #(.WRITE_CYCLES(WC)) uut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .sdaOut(sdaOut), .strapA2(1'b1), .strapA1(1'b0), .wpIn(wp)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dev(input logic blk, input logic rd);
    return {4'b1010, 1'b1, 1'b0, blk, rd};
  endfunction

  task automatic busStart();
    mSda = 1'b1; tick(Q);
    mScl = 1'b1; tick(Q);
    mSda = 1'b0; tick(Q);
    mScl = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    mSda = 1'b0; tick(Q);
    mScl = 1'b1; tick(Q);
    mSda = 1'b1; tick(2 * Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; tick(Q);
      mScl = 1'b1; tick(2 * Q);
      mScl = 1'b0; tick(Q);
    end
    mSda = 1'b1; tick(Q);
    mScl = 1'b1; tick(Q);
    ack = (sdaLine == 1'b0);
    tick(Q);
    mScl = 1'b0; tick(Q);
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      mSda = 1'b1; tick(Q);
      mScl = 1'b1; tick(Q);
      d[i] = sdaLine;
      tick(Q);
      mScl = 1'b0; tick(Q);
    end
    mSda = !ackIt; tick(Q);
    mScl = 1'b1; tick(2 * Q);
    mScl = 1'b0; tick(Q);
  endtask

  task automatic beginRead(input logic [8:0] a, output logic ok);
    logic a1, a2, a3;
    busStart();
    sendByte(dev(a[8], 1'b0), a1);
    sendByte(a[7:0], a2);
    busStart();
    sendByte(dev(a[8], 1'b1), a3);
    ok = a1 && a2 && a3;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack, ok;
    logic [7:0] d;
    tick(5);
    rstN = 1'b1;
    tick(5);

    // R1: reset state
    check("R1 released", sdaOe, 1'b0);
    busStart();
    sendByte(dev(1'b0, 1'b1), ack);
    check("R1 R2 device ack", ack, 1'b1);
    recvByte(1'b0, d);
    busStop();
    check("R1 erased byte at 0", d, 8'hFF);

    // R2: strap mismatches are not acknowledged
    busStart();
    sendByte(8'hA0, ack);
    check("R2 A2 mismatch nack", ack, 1'b0);
    busStop();
    busStart();
    sendByte(8'hAC, ack);
    check("R2 A1 mismatch nack", ack, 1'b0);
    busStop();
    check("R2 bus released", sdaOe, 1'b0);

    // R3 R4: vector table of byte writes and read-backs
    for (int v = 0; v < 6; v++) begin
      logic a1, a2, a3;
      wp = VECS[v][8];
      busStart();
      sendByte(dev(VECS[v][25], 1'b0), a1);
      sendByte(VECS[v][24:17], a2);
      sendByte(VECS[v][16:9], a3);
      busStop();
      check("R4 data acked", {a1, a2, a3}, 3'b111);
      tick(WC + 200);
      wp = 1'b0;
      beginRead(VECS[v][25:17], ok);
      recvByte(1'b0, d);
      busStop();
      check("R3 R4 R7 read back", {ok, d}, {1'b1, VECS[v][7:0]});
    end

    // R5 R6: page write of 18 bytes at 0x020
    busStart();
    sendByte(dev(1'b0, 1'b0), ack);
    sendByte(8'h20, ack);
    for (int i = 0; i < 18; i++) sendByte(8'h80 + 8'(i), ack);
    busStop();
    busStart();
    sendByte(dev(1'b0, 1'b0), ack);
    busStop();
    check("R6 busy nack", ack, 1'b0);
    tick(WC + 200);
    busStart();
    sendByte(dev(1'b0, 1'b0), ack);
    busStop();
    check("R6 ack after busy", ack, 1'b1);

    beginRead(9'h020, ok);
    recvByte(1'b0, d);
    busStop();
    check("R5 R7 page wrap first", {ok, d}, {1'b1, 8'h90});

    // R8: current-address read continues at 0x021
    busStart();
    sendByte(dev(1'b0, 1'b1), ack);
    recvByte(1'b0, d);
    busStop();
    check("R8 current address", {ack, d}, {1'b1, 8'h91});

    // R9: sequential read 0x022..0x030 crosses the page edge
    busStart();
    sendByte(dev(1'b0, 1'b1), ack);
    for (int j = 0; j < 15; j++) begin
      recvByte(j != 14, d);
      check("R5 R9 sequential", d, (j < 14) ? 8'h82 + 8'(j) : 8'hFF);
    end
    busStop();

    // R9: wrap from top of array to 0
    beginRead(9'h1FF, ok);
    recvByte(1'b1, d);
    check("R9 top byte", {ok, d}, {1'b1, 8'h12});
    recvByte(1'b0, d);
    check("R9 wrap to 0", d, 8'h5A);
    busStop();
    check("R9 R10 released after nack", sdaOe, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule